// File: doc/BRIEF.md
# SMRAM Window Remap Decoder

This block holds the three configuration bytes that define where system-management RAM appears to the host: a target base byte, a control byte and the E-segment shadow byte. On every accepted configuration write it rebuilds up to two remap windows from these bytes. Each window has a host start address, a physical target, a size of 32 KB or 64 KB, and a visibility flag.

A combinational lookup port takes a host address. It reports whether the address falls inside an enabled window. On a hit it also gives the translated physical address and that window's visibility flag. A memory-path controller uses the lookup to steer management-mode accesses to the reserved DRAM area.

Top module: `smram_remap`

## Requirements
- R1: After reset all three bytes read as 00h and no window is enabled until the first accepted configuration write. A lookup at A0000h or E0000h misses.
- R2: The write select encodes the target byte as 0, the control byte as 1 and the shadow byte as 2. Select 3 is ignored and leaves the windows as they were. An accepted write changes the lookup result from the clock edge that captures it.
- R3: The target base is the target byte shifted left by 20, ORed with control bits 2:0 shifted left by 28.
- R4: The mode is control bits 7:5. On a hit, control bit 4 is reported as the visibility flag.
- R5: In any non-zero mode, a target base of zero enables no window.
- R6: In mode 0, when the shadow byte is exactly 00h, host range A0000h–AFFFFh maps to E0000h plus the offset.
- R7: In mode 0, when shadow bits 7:6 are both 0, host range E0000h–E7FFFh maps to itself. This does not depend on R6.
- R8: Mode 1 maps the 64 KB host range at B0000h to the target base. Mode 2 does the same for the 64 KB range at A0000h.
- R9: Mode 4 maps the 32 KB host range at A0000h to the target base. Mode 6 does the same for the 32 KB range at B0000h.
- R10: Modes 3, 5 and 7 enable no window.
- R11: The translated address is the window target plus (address minus window start). The window end is exclusive. On a miss both the address and the visibility flag are 0. If windows overlap, the lower-numbered window wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Byte select: 0 target, 1 control, 2 shadow, 3 none |
| cfg_wdata | input | 8 | Write data |
| look_addr | input | 32 | Host address to translate |
| look_hit | output | 1 | Address lies in an enabled window |
| look_phys | output | 32 | Translated physical address, 0 on miss |
| look_vis | output | 1 | Visibility flag of the hit window, 0 on miss |

## Verification
The bench uses the default 32-bit address width. At that width, control bits 2:0 land on the top nibble of the target base, so bases near 7FF0_0000h and carries out of the base byte are reachable. Random target and shadow bytes are drawn with extra weight on 00h and on shadow values with bits 7:6 clear. This keeps the zero-base suppression and both mode-0 windows covered. Lookup addresses cluster around the A0000h–F0000h segment edges, so each window start and exclusive end gets hit.

// File: rtl/smram_pkg.sv
package smram_pkg;
    parameter int AW     = 32;
    parameter int BW     = 8;
    parameter int NWIN   = 2;
    parameter int SZ_LOG = 15;
    localparam logic [AW-1:0] SEG_A  = AW'(32'h000A_0000);
    localparam logic [AW-1:0] SEG_B  = AW'(32'h000B_0000);
    localparam logic [AW-1:0] SEG_E  = AW'(32'h000E_0000);
    localparam logic [AW-1:0] SZ_32K = AW'(1) << SZ_LOG;
    localparam logic [AW-1:0] SZ_64K = AW'(1) << (SZ_LOG + 1);

    typedef struct packed {
        logic          en;
        logic          vis;
        logic          big;
        logic [AW-1:0] start;
        logic [AW-1:0] target;
    } win_t;

    typedef struct packed {
        logic [BW-1:0] tgt;
        logic [BW-1:0] ctl;
        logic [BW-1:0] shd;
    } cfg_t;
endpackage

// File: rtl/smram_win_calc.sv
module smram_win_calc
    import smram_pkg::*;
(
    input  cfg_t                  cfg,
    output win_t [NWIN-1:0]       wins
);
    logic [AW-1:0] base;
    logic [2:0]    mode;
    logic          vis;

    always_comb begin
        base = (AW'(cfg.tgt) << 20) | (AW'(cfg.ctl[2:0]) << 28);
        mode = cfg.ctl[7:5];
        vis  = cfg.ctl[4];
        wins = '0;
        for (int i = 0; i < NWIN; i++) wins[i].vis = vis;
        if (mode == 3'd0) begin
            wins[0].en     = (cfg.shd == '0);
            wins[0].big    = 1'b1;
            wins[0].start  = SEG_A;
            wins[0].target = SEG_E;
            wins[1].en     = (cfg.shd[7:6] == 2'b00);
            wins[1].big    = 1'b0;
            wins[1].start  = SEG_E;
            wins[1].target = SEG_E;
        end else if (base != '0) begin
            wins[0].target = base;
            case (mode)
                3'd1: begin wins[0].en = 1'b1; wins[0].big = 1'b1; wins[0].start = SEG_B; end
                3'd2: begin wins[0].en = 1'b1; wins[0].big = 1'b1; wins[0].start = SEG_A; end
                3'd4: begin wins[0].en = 1'b1; wins[0].big = 1'b0; wins[0].start = SEG_A; end
                3'd6: begin wins[0].en = 1'b1; wins[0].big = 1'b0; wins[0].start = SEG_B; end
                default: wins[0].en = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/smram_win_match.sv
module smram_win_match
    import smram_pkg::*;
(
    input  win_t          win,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [AW-1:0] phys
);
    logic [AW:0]   lim;
    logic [AW-1:0] off;

    always_comb begin
        lim  = {1'b0, win.start} + {1'b0, (win.big ? SZ_64K : SZ_32K)};
        off  = addr - win.start;
        hit  = win.en && (addr >= win.start) && ({1'b0, addr} < lim);
        phys = win.target + off;
    end
endmodule

// File: rtl/smram_remap.sv
module smram_remap
    import smram_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [7:0]    cfg_wdata,
    input  logic [31:0]   look_addr,
    output logic          look_hit,
    output logic [31:0]   look_phys,
    output logic          look_vis
);
    cfg_t            cfg_d, cfg_q;
    win_t [NWIN-1:0] win_d, win_q, win_calc;
    logic [NWIN-1:0] hits;
    logic [AW-1:0]   phys [NWIN];
    logic            accept;

    always_comb begin
        cfg_d  = cfg_q;
        accept = cfg_wr && (cfg_sel != 2'd3);
        if (cfg_wr) begin
            case (cfg_sel)
                2'd0: cfg_d.tgt = cfg_wdata;
                2'd1: cfg_d.ctl = cfg_wdata;
                2'd2: cfg_d.shd = cfg_wdata;
                default: cfg_d = cfg_q;
            endcase
        end
    end

    smram_win_calc u_calc (.cfg(cfg_d), .wins(win_calc));

    always_comb begin
        win_d = accept ? win_calc : win_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            win_q <= '0;
        end else begin
            cfg_q <= cfg_d;
            win_q <= win_d;
        end
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_match
        smram_win_match u_match (
            .win  (win_q[g]),
            .addr (look_addr),
            .hit  (hits[g]),
            .phys (phys[g])
        );
    end

    always_comb begin
        look_hit  = 1'b0;
        look_phys = '0;
        look_vis  = 1'b0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                look_hit  = 1'b1;
                look_phys = phys[i];
                look_vis  = win_q[i].vis;
            end
        end
    end

    logic [AW-1:0] base_q;
    assign base_q = (AW'(cfg_q.tgt) << 20) | (AW'(cfg_q.ctl[2:0]) << 28);

    assert_zero_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q[0].en || win_q[1].en) |-> (cfg_q.ctl[7:5] == 3'd0 || base_q != '0));

    assert_dead_modes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.ctl[7:5] == 3'd3 || cfg_q.ctl[7:5] == 3'd5 || cfg_q.ctl[7:5] == 3'd7)
        |-> !(win_q[0].en || win_q[1].en));

    assert_mode0_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.ctl[7:5] == 3'd0 && cfg_q.shd != 8'h00) |-> !win_q[0].en);

    assert_miss_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !look_hit |-> (look_phys == '0 && !look_vis));

    assert_ignored_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == 2'd3) |=> $stable(win_q));

    assert_vis_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        look_hit |-> (look_vis == cfg_q.ctl[4]));
endmodule

// File: tb/smram_remap_tb.sv
module smram_remap_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [31:0] look_addr = '0;
    logic        look_hit;
    logic [31:0] look_phys;
    logic        look_vis;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_tgt = 0, m_ctl = 0, m_shd = 0;
    logic       m_arm = 0;

    always #10 clk = ~clk;

    smram_remap u_dut (.*);

    function automatic logic [33:0] ref_look(input logic [31:0] a);
        logic [31:0] base, st, sz, tg;
        logic [2:0]  md;
        logic        en;
        base = ({24'd0, m_tgt} << 20) | ({29'd0, m_ctl[2:0]} << 28);
        md   = m_ctl[7:5];
        if (!m_arm) return '0;
        if (md == 3'd0) begin
            if (m_shd == 8'h00 && a >= 32'hA0000 && a < 32'hB0000)
                return {1'b1, m_ctl[4], 32'hE0000 + (a - 32'hA0000)};
            if (m_shd[7:6] == 2'b00 && a >= 32'hE0000 && a < 32'hE8000)
                return {1'b1, m_ctl[4], a};
            return '0;
        end
        if (base == 0) return '0;
        en = 1'b1; st = 0; sz = 0; tg = base;
        case (md)
            3'd1: begin st = 32'hB0000; sz = 32'h10000; end
            3'd2: begin st = 32'hA0000; sz = 32'h10000; end
            3'd4: begin st = 32'hA0000; sz = 32'h8000; end
            3'd6: begin st = 32'hB0000; sz = 32'h8000; end
            default: en = 1'b0;
        endcase
        if (en && a >= st && a < st + sz) return {1'b1, m_ctl[4], tg + (a - st)};
        return '0;
    endfunction

    function automatic string tag_for(input logic [31:0] a);
        case (m_ctl[7:5])
            3'd0: return (a >= 32'hE0000) ? "R7" : "R6";
            3'd1, 3'd2: return "R8";
            3'd4, 3'd6: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (s == 2'd0) m_tgt = d;
        if (s == 2'd1) m_ctl = d;
        if (s == 2'd2) m_shd = d;
        if (s != 2'd3) m_arm = 1'b1;
    endtask

    task automatic look(input logic [31:0] a, input string req);
        logic [33:0] e;
        look_addr = a;
        #1;
        e = ref_look(a);
        n_chk++;
        if ({look_hit, look_vis, look_phys} !== e) begin
            n_bad++;
            $display("FAIL %s addr=%h act hit=%b vis=%b phys=%h exp hit=%b vis=%b phys=%h",
                     req, a, look_hit, look_vis, look_phys, e[33], e[32], e[31:0]);
        end
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7781));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: nothing enabled after reset
        look(32'hA0000, "R1");
        look(32'hE0000, "R1");
        // R2: select 3 ignored, nothing armed
        wr(2'd3, 8'h00);
        look(32'hA0000, "R2");
        // R6 R7: mode 0, shadow 00h
        wr(2'd2, 8'h00);
        look(32'hA0000, "R6"); look(32'hAFFFF, "R6"); look(32'hB0000, "R11");
        look(32'hE7FFF, "R7"); look(32'hE8000, "R11");
        wr(2'd2, 8'h3F);
        look(32'hA1234, "R6"); look(32'hE0010, "R7");
        wr(2'd2, 8'h40);
        look(32'hE0010, "R7");
        // R3 R4 R8: mode 1 with high base bits and visibility
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h37);
        look(32'hB0000, "R3"); look(32'hBFFFF, "R8"); look(32'hC0000, "R11");
        wr(2'd1, 8'h27);
        look(32'hB0004, "R4");
        // R2: select 3 leaves state
        wr(2'd3, 8'h00);
        look(32'hB0004, "R2");
        // R5: zero base in mode 2
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h40);
        look(32'hA0000, "R5");
        wr(2'd0, 8'h12);
        look(32'hA8000, "R8");
        // R9: mode 4 / 6 boundaries
        wr(2'd1, 8'h91);
        look(32'hA7FFF, "R9"); look(32'hA8000, "R9");
        wr(2'd1, 8'hC0);
        look(32'hB7FFF, "R9"); look(32'hB8000, "R9");
        // R10: dead modes
        wr(2'd1, 8'h60); look(32'hA0000, "R10"); look(32'hB0000, "R10");
        wr(2'd1, 8'hA5); look(32'hA0000, "R10");
        wr(2'd1, 8'hF2); look(32'hB0000, "R10");
        // random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            logic [31:0] a;
            r = $urandom % 8;
            if (r == 0) wr(2'd0, ($urandom % 3 == 0) ? 8'h00 : 8'($urandom));
            else if (r == 1) wr(2'd1, 8'($urandom));
            else if (r == 2) wr(2'd2, ($urandom % 2 == 0) ? 8'($urandom % 64) : 8'($urandom));
            else if (r == 3) wr(2'd3, 8'($urandom));
            a = 32'h98000 + ($urandom % 32'h60000);
            if ($urandom % 4 == 0) a = 32'hA0000 + (($urandom % 12) * 32'h8000) - ($urandom % 2);
            look(a, tag_for(a));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule